// File: doc/BRIEF.md
# Dual-Rail Clock Pulse Error Detector

This block watches a count input and a redundant copy of it that is carried in inverted form. Every rising edge on the primary rail (`sig_a`) must be answered by a falling edge on the complementary rail (`sig_b`) within a window of `WINDOW` system clock cycles. The check also runs the other way: a falling edge on the complementary rail must be answered by a rising edge on the primary rail. Each edge left without a partner counts as one error.

The error count saturates. Once it reaches `ERR_LIMIT` (three by default), the error output goes high and stays high until the count is cleared. Both rails are sampled on the system clock. A synchronous clear wipes the error state. An enable input switches the whole check off, and while it is off the output is forced low. Typical use is on a pulse or event counter input whose wiring is duplicated to catch a broken or noisy line.

Top module: `pulse_pair_checker`

## Requirements
- R1: A rising edge on `sig_a` followed by a falling edge on `sig_b` 0 to `WINDOW` cycles later, or a `sig_b` fall followed by an `sig_a` rise in the same span, counts no error.
- R2: A rising edge on `sig_a` that gets no `sig_b` fall within `WINDOW` cycles counts one error in the cycle `WINDOW`+1 after the edge.
- R3: A falling edge on `sig_b` that gets no `sig_a` rise within `WINDOW` cycles counts one error in the same way.
- R4: An edge that is waiting is paired with the next opposite edge. A new edge on the same rail while one is waiting counts one error for the older edge and then becomes the waiting edge. When both edges arrive in the same cycle they pair with each other if nothing waits. If something waits, the opposite edge in that cycle pairs with the waiting edge and the other edge of the pair starts a new wait.
- R5: `err_flag` goes high at the clock edge where the `ERR_LIMIT`-th error (third by default) is counted. Further errors leave it high.
- R6: `clr` high at a clock edge clears the error count and any waiting edge, and drives `err_flag` low after that edge.
- R7: While `en` is low, no error is counted, waiting edges are dropped, the count is cleared and `err_flag` is low.
- R8: An edge is a change between two consecutive clock samples: `sig_a` going 0 to 1, or `sig_b` going 1 to 0. Steady levels create no events. After reset the previous samples are taken as `sig_a`=0 and `sig_b`=1.
- R9: With fewer than `ERR_LIMIT` errors counted since the last clear, `err_flag` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of the error state (master reset) |
| en | input | 1 | Checking enable, active high |
| sig_a | input | 1 | Primary count rail, checked for rising edges |
| sig_b | input | 1 | Complementary rail, checked for falling edges |
| err_flag | output | 1 | High once the error limit has been reached |

## Verification
The bench drives pairs at offsets of 0, 2 and `WINDOW` cycles, which must not count. It also drives lone edges on each rail, which must count at `WINDOW`+1. A failure in the first case separates an over-eager checker from a correct one, and the second case exposes a window that is off by one. Repeated same-rail edges and simultaneous edges arriving while another edge waits show whether the pairing order and the replacement error are handled as specified. Clears and disables are applied part-way through an error run, and long steady levels are held on both rails. These runs reveal state that survives a clear, or levels that are mistaken for edges.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
    typedef enum logic {
        SIDE_A = 1'b0,
        SIDE_B = 1'b1
    } side_e;
endpackage

// File: rtl/ppc_edge.sv
// Detects one edge polarity on a rail sampled by the system clock.
module ppc_edge #(
    parameter bit RISING = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic evt
);
    localparam logic IDLE = RISING ? 1'b0 : 1'b1;

    logic prev_d, prev_q;

    always_comb begin
        prev_d = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= IDLE;
        else        prev_q <= prev_d;
    end

    generate
        if (RISING) begin : g_rise
            assign evt = din & ~prev_q;
        end else begin : g_fall
            assign evt = ~din & prev_q;
        end
    endgenerate
endmodule

// File: rtl/ppc_pair_tracker.sv
// Holds at most one edge waiting for its partner and ages it.
module ppc_pair_tracker #(
    parameter int WINDOW = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic ev_a,
    input  logic ev_b,
    output logic err_inc,
    output logic pend_valid
);
    import ppc_pkg::*;

    localparam int CW = (WINDOW < 1) ? 1 : $clog2(WINDOW + 1);
    localparam logic [CW-1:0] RELOAD = CW'(WINDOW);

    typedef struct packed {
        logic          valid;
        side_e         side;
        logic [CW-1:0] left;
    } wait_t;

    wait_t st_d, st_q;
    logic  err_d;
    logic  live;

    always_comb begin
        st_d  = st_q;
        err_d = 1'b0;
        live  = st_q.valid;
        if (st_q.valid && st_q.left == '0) begin
            err_d = 1'b1;
            live  = 1'b0;
        end
        if (flush) begin
            st_d  = '0;
            err_d = 1'b0;
        end else begin
            unique case ({ev_a, ev_b})
                2'b00: begin
                    if (live) st_d.left = st_q.left - 1'b1;
                    else      st_d.valid = 1'b0;
                end
                2'b10: begin
                    if (live && st_q.side == SIDE_B) begin
                        st_d.valid = 1'b0;
                    end else begin
                        if (live) err_d = 1'b1;
                        st_d.valid = 1'b1;
                        st_d.side  = SIDE_A;
                        st_d.left  = RELOAD;
                    end
                end
                2'b01: begin
                    if (live && st_q.side == SIDE_A) begin
                        st_d.valid = 1'b0;
                    end else begin
                        if (live) err_d = 1'b1;
                        st_d.valid = 1'b1;
                        st_d.side  = SIDE_B;
                        st_d.left  = RELOAD;
                    end
                end
                default: begin
                    if (live) st_d.left  = RELOAD;
                    else      st_d.valid = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err_inc    = err_d;
    assign pend_valid = st_q.valid;
endmodule

// File: rtl/ppc_err_accum.sv
// Saturating error counter and sticky limit flag.
module ppc_err_accum #(
    parameter int ERR_LIMIT = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             flush,
    input  logic                             inc,
    output logic [$clog2(ERR_LIMIT+1)-1:0]   err_cnt,
    output logic                             flag
);
    localparam int EW = $clog2(ERR_LIMIT + 1);
    localparam logic [EW-1:0] TOP = EW'(ERR_LIMIT);

    typedef struct packed {
        logic [EW-1:0] cnt;
        logic          flag;
    } acc_t;

    acc_t acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (flush) begin
            acc_d.cnt = '0;
        end else if (inc && acc_q.cnt < TOP) begin
            acc_d.cnt = acc_q.cnt + 1'b1;
        end
        acc_d.flag = (acc_d.cnt >= TOP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign err_cnt = acc_q.cnt;
    assign flag    = acc_q.flag;
endmodule

// File: rtl/pulse_pair_checker.sv
module pulse_pair_checker #(
    parameter int WINDOW    = 4,
    parameter int ERR_LIMIT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic sig_a,
    input  logic sig_b,
    output logic err_flag
);
    localparam int EW = $clog2(ERR_LIMIT + 1);

    logic          ev_a, ev_b;
    logic          flush;
    logic          err_inc;
    logic          pend_valid;
    logic [EW-1:0] err_cnt;

    assign flush = clr | ~en;

    ppc_edge #(.RISING(1'b1)) u_edge_a (
        .clk(clk), .rst_n(rst_n), .din(sig_a), .evt(ev_a)
    );

    ppc_edge #(.RISING(1'b0)) u_edge_b (
        .clk(clk), .rst_n(rst_n), .din(sig_b), .evt(ev_b)
    );

    ppc_pair_tracker #(.WINDOW(WINDOW)) u_track (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .ev_a(ev_a), .ev_b(ev_b),
        .err_inc(err_inc), .pend_valid(pend_valid)
    );

    ppc_err_accum #(.ERR_LIMIT(ERR_LIMIT)) u_acc (
        .clk(clk), .rst_n(rst_n), .flush(flush), .inc(err_inc),
        .err_cnt(err_cnt), .flag(err_flag)
    );
endmodule

// File: rtl/ppc_sva.sv
module ppc_sva #(
    parameter int WINDOW    = 4,
    parameter int ERR_LIMIT = 3
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           clr,
    input logic                           en,
    input logic                           err_flag,
    input logic                           err_inc,
    input logic                           pend_valid,
    input logic                           ev_a,
    input logic                           ev_b,
    input logic [$clog2(ERR_LIMIT+1)-1:0] err_cnt
);
    AST_CLEAR_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !err_flag); // R6

    AST_OFF_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !err_flag); // R7

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && en && !clr) |=> err_flag); // R5

    AST_FLAG_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> ($past(err_inc) && ($past(err_cnt) == ERR_LIMIT - 1))); // R5

    AST_NO_WAIT_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && !pend_valid) |-> !err_inc); // R1

    AST_SAME_CYCLE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && ev_a && ev_b && !pend_valid) |=> !pend_valid); // R4

    AST_COUNT_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_cnt != $past(err_cnt)) && (err_cnt != 0)) |-> (err_cnt == $past(err_cnt) + 1)); // R9
endmodule

bind pulse_pair_checker ppc_sva #(.WINDOW(WINDOW), .ERR_LIMIT(ERR_LIMIT)) u_sva (
    .clk(clk), .rst_n(rst_n), .clr(clr), .en(en), .err_flag(err_flag),
    .err_inc(err_inc), .pend_valid(pend_valid), .ev_a(ev_a), .ev_b(ev_b),
    .err_cnt(err_cnt)
);

// File: tb/sim_pulse_pair_checker.sv
`timescale 1ns/100ps
module sim_pulse_pair_checker;
    localparam int W = 4;
    localparam int LIM = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic en = 1'b1;
    logic sa = 1'b0;
    logic sb = 1'b1;
    logic err_flag;

    int checks = 0;
    int errors = 0;
    string cur_req = "R8";
    bit exp_flag = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pulse_pair_checker #(.WINDOW(W), .ERR_LIMIT(LIM)) u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .en(en),
        .sig_a(sa), .sig_b(sb), .err_flag(err_flag)
    );

    // Behavioural reference: list of waiting edges with time stamps.
    int  wt_time[$];
    bit  wt_side[$];   // 0: primary rail rise, 1: complementary rail fall
    int  errs = 0;
    int  now = 0;
    bit  prev_a = 1'b0, prev_b = 1'b1;

    always @(posedge clk) begin
        bit ea, eb, s;
        if (!rst_n) begin
            wt_time.delete(); wt_side.delete();
            errs = 0; prev_a = 1'b0; prev_b = 1'b1; exp_flag = 1'b0;
        end else begin
            now++;
            ea = sa && !prev_a;
            eb = !sb && prev_b;
            prev_a = sa; prev_b = sb;
            if (clr || !en) begin
                wt_time.delete(); wt_side.delete(); errs = 0;
            end else begin
                if (wt_time.size() > 0 && now - wt_time[0] > W) begin
                    errs++; void'(wt_time.pop_front()); void'(wt_side.pop_front());
                end
                if (ea && eb) begin
                    if (wt_time.size() > 0) begin
                        s = wt_side[0];
                        void'(wt_time.pop_front()); void'(wt_side.pop_front());
                        wt_time.push_back(now); wt_side.push_back(s);
                    end
                end else if (ea || eb) begin
                    s = eb;
                    if (wt_time.size() > 0 && wt_side[0] != s) begin
                        void'(wt_time.pop_front()); void'(wt_side.pop_front());
                    end else begin
                        if (wt_time.size() > 0) begin
                            errs++; void'(wt_time.pop_front()); void'(wt_side.pop_front());
                        end
                        wt_time.push_back(now); wt_side.push_back(s);
                    end
                end
            end
            exp_flag = (errs >= LIM);
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (err_flag !== exp_flag) begin
                errors++;
                $display("FAIL %s cycle %0d: err_flag=%b expected=%b", cur_req, now, err_flag, exp_flag);
            end
        end
    end

    task automatic step(int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic expect_flag(bit v, string req);
        @(negedge clk);
        checks++;
        if (err_flag !== v) begin
            errors++;
            $display("FAIL %s: err_flag=%b expected=%b", req, err_flag, v);
        end
        @(posedge clk);
        #1;
    endtask

    task automatic pair(int d);
        sa = 1'b1;
        if (d == 0) sb = 1'b0;
        step(1);
        if (d > 0) begin
            step(d - 1);
            sb = 1'b0;
            step(1);
        end
        step(1);
        sa = 1'b0; sb = 1'b1;
        step(W + 3);
    endtask

    task automatic pair_ba(int d);
        sb = 1'b0;
        step(1);
        if (d > 1) step(d - 1);
        sa = 1'b1;
        step(2);
        sa = 1'b0; sb = 1'b1;
        step(W + 3);
    endtask

    task automatic lone_a();
        sa = 1'b1; step(2); sa = 1'b0; step(W + 3);
    endtask

    task automatic lone_b();
        sb = 1'b0; step(2); sb = 1'b1; step(W + 3);
    endtask

    task automatic do_clear();
        clr = 1'b1; step(1); clr = 1'b0; step(1);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        cur_req = "R8";
        expect_flag(1'b0, "R8 reset state");
        step(20);
        expect_flag(1'b0, "R8 idle levels");

        cur_req = "R1";
        pair(0); pair(2); pair(W); pair(W); pair(1);
        pair_ba(2); pair_ba(W);
        expect_flag(1'b0, "R1 matched pairs");

        cur_req = "R2";
        lone_a(); lone_a();
        expect_flag(1'b0, "R9 two errors");
        lone_a();
        expect_flag(1'b1, "R2 three lone rises");
        cur_req = "R6";
        do_clear();
        expect_flag(1'b0, "R6 clear after flag");

        cur_req = "R2";
        pair(W + 1); pair(W + 1); pair(W + 1);
        expect_flag(1'b1, "R2 partner one cycle late");
        do_clear();

        cur_req = "R3";
        lone_b(); lone_b(); lone_b();
        expect_flag(1'b1, "R3 three lone falls");
        do_clear();

        cur_req = "R4";
        repeat (3) begin
            sa = 1'b1; step(1); sa = 1'b0; step(1);
            sa = 1'b1; step(1);
            sb = 1'b0; step(2);
            sa = 1'b0; sb = 1'b1; step(W + 3);
        end
        expect_flag(1'b1, "R4 repeated rise while waiting");
        do_clear();
        repeat (4) begin
            sa = 1'b1; step(1); sa = 1'b0; step(1);
            sa = 1'b1; sb = 1'b0; step(1);
            sb = 1'b1; step(1); sb = 1'b0; step(1);
            sa = 1'b0; sb = 1'b1; step(W + 3);
        end
        expect_flag(1'b0, "R4 simultaneous edges with one waiting");
        repeat (5) pair(0);
        expect_flag(1'b0, "R4 simultaneous edges, none waiting");

        cur_req = "R5";
        repeat (5) lone_a();
        expect_flag(1'b1, "R5 saturated after five errors");
        step(15);
        expect_flag(1'b1, "R5 flag holds");
        do_clear();

        cur_req = "R6";
        lone_a(); lone_a();
        sa = 1'b1; step(1);
        clr = 1'b1; step(1); clr = 1'b0; sa = 1'b0;
        step(W + 3);
        lone_a(); lone_a();
        expect_flag(1'b0, "R6 clear drops count and waiting edge");
        do_clear();

        cur_req = "R7";
        lone_b(); lone_b();
        en = 1'b0;
        step(2);
        lone_a(); lone_b(); lone_a(); lone_b();
        expect_flag(1'b0, "R7 disabled ignores errors");
        sa = 1'b1; step(1);
        en = 1'b1; step(1);
        sa = 1'b0; step(W + 3);
        lone_a(); lone_a();
        expect_flag(1'b0, "R7 count cleared while disabled");
        do_clear();

        cur_req = "R8";
        sa = 1'b1; sb = 1'b0; step(30);
        expect_flag(1'b0, "R8 held levels");
        sa = 1'b0; sb = 1'b1; step(30);
        expect_flag(1'b0, "R8 return to idle");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule